// File: doc/BRIEF.md
# 32-Source Interrupt Controller

This block gathers 32 interrupt lines from peripherals and turns them into two request lines toward a processor. Each line has its own 3-bit trigger code. The code selects one of five behaviours: off, rising edge, falling edge, either edge, or a live active-high or active-low level. Every line first passes through a two-flop synchronizer. Edge events are kept in two sticky status words, one for rising edges and one for falling edges, until software clears them. Level lines are evaluated live and are never latched.

Software programs and observes the block over a plain single-cycle register port. A write takes effect at the clock edge on which `reg_we` is high. Reads are combinational from `reg_addr`. The port has no handshake and no back-pressure, because every access completes in the cycle it is presented. There are seven control words: three trigger-code planes, enable, wake-enable, route and source. Each control word has its own read, set and clear address, so two agents can change separate bits without a read-modify-write.

An enabled source appears in one of two pending words, chosen by its route bit. Each request output is the registered OR of its pending word. A separate wake output flags any wake-enabled source whose trigger condition is active, whatever its enable bit.

Top module: `intc32_top`

## Requirements
- R1: While reset is asserted, and directly after it, the block holds the safe state. Every trigger-code plane reads 0, the enable and wake words read 0, the route and source words read all ones, both edge words and the test word read 0, and `irq_req0`, `irq_req1` and `wake_out` are low.
- R2: Control word k is at these addresses: read at 4k, set at 4k+1, clear at 4k+2. The words are k=0 code plane 0, 1 code plane 1, 2 code plane 2, 3 enable, 4 wake-enable, 5 route, 6 source. A write to the set address sets each bit written as 1, a write to the clear address clears each bit written as 1, and bits written as 0 keep their value.
- R3: With code {plane2,plane1,plane0} = 001, a rising edge on the synchronized input sets the source's bit in the rising-edge word (read at 28). The bit stays set after the input falls again. Writing 1 to that bit at address 29 clears it, and writing 0 leaves it unchanged.
- R4: Code 010 latches falling edges into the falling-edge word (read 30, write-1-clear 31). Code 011 latches both edges. An edge of the opposite direction never makes such a source pending.
- R5: Code 101 makes the source pending exactly while its synchronized input is high, and code 110 exactly while it is low. Neither level code latches anything.
- R6: Code 000, and the unused codes 100 and 111, never make a source pending.
- R7: A source whose enable bit is clear shows in neither pending word and raises no request. Its edge latch is kept, so setting the enable bit later makes the held event pending.
- R8: A pending source appears in pending word 0 (address 32) when its route bit is 1, and in pending word 1 (address 33) when its route bit is 0. It never appears in both.
- R9: `irq_req0` and `irq_req1` are the OR of pending words 0 and 1, delayed by one register. A level input change shows in its pending word two clocks after it is driven, and on its request pin three clocks after it is driven.
- R10: `wake_out` is high one clock after any source with a set wake-enable bit has an active trigger condition, and it ignores the enable word.
- R11: When an edge event and a write-1-clear for the same latch bit land on the same clock edge, the latch stays set.
- R12: The test word at address 34 is a plain 32-bit read/write register and has no effect on pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset to the safe state |
| irq_in | input | NSRC | Asynchronous interrupt lines, one per source |
| reg_we | input | 1 | Register write strobe, one access per cycle |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | NSRC | Register write data |
| reg_rdata | output | NSRC | Combinational read data for `reg_addr` |
| irq_req0 | output | 1 | Registered request for sources routed to output 0 |
| irq_req1 | output | 1 | Registered request for sources routed to output 1 |
| wake_out | output | 1 | Registered wake indication |

## Verification
The hardest case to reach is an edge event and a software clear of the same latch bit on the same clock edge, because the edge lands only after a fixed number of synchronizer stages. The bench drives the input on a falling clock edge and counts the two synchronizer registers and the edge-detect register. It then places the clear write so that it is captured on the same rising edge as the latch update, and reads the rising-edge word back. The one-cycle request latency is handled the same way: a level input is driven and both the pending word and the request pin are sampled on each of the following falling edges.

// File: rtl/intc32_pkg.sv
package intc32_pkg;

  // number of set/clear/read control words
  localparam int NCTL = 7;

  // control word indices (read at 4k, set at 4k+1, clear at 4k+2)
  localparam int W_CODE0 = 0;
  localparam int W_CODE1 = 1;
  localparam int W_CODE2 = 2;
  localparam int W_ENA   = 3;
  localparam int W_WAKE  = 4;
  localparam int W_ROUTE = 5;
  localparam int W_SRC   = 6;

  // other addresses
  localparam int A_RISE_RD  = 28;
  localparam int A_RISE_CLR = 29;
  localparam int A_FALL_RD  = 30;
  localparam int A_FALL_CLR = 31;
  localparam int A_PEND0    = 32;
  localparam int A_PEND1    = 33;
  localparam int A_TEST     = 34;

  // trigger codes {plane2, plane1, plane0}
  localparam logic [2:0] TRG_OFF  = 3'b000;
  localparam logic [2:0] TRG_RISE = 3'b001;
  localparam logic [2:0] TRG_FALL = 3'b010;
  localparam logic [2:0] TRG_BOTH = 3'b011;
  localparam logic [2:0] TRG_HIGH = 3'b101;
  localparam logic [2:0] TRG_LOW  = 3'b110;

  // safe-state value of a control word: route and source reset to ones
  function automatic bit ctl_resets_high(input int k);
    return (k == W_ROUTE) || (k == W_SRC);
  endfunction

endpackage

// File: rtl/intc32_edge_front.sv
module intc32_edge_front #(
  parameter int NSRC        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lines,
  output logic [NSRC-1:0] level,
  output logic [NSRC-1:0] rise_ev,
  output logic [NSRC-1:0] fall_ev
);

  logic [SYNC_STAGES-1:0][NSRC-1:0] stage_q;
  logic [NSRC-1:0]                  prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      prev_q  <= '0;
    end else begin
      stage_q <= {stage_q[SYNC_STAGES-2:0], lines};
      prev_q  <= stage_q[SYNC_STAGES-1];
    end
  end

  assign level   = stage_q[SYNC_STAGES-1];
  assign rise_ev = level & ~prev_q;
  assign fall_ev = ~level & prev_q;

endmodule

// File: rtl/intc32_ctl_regs.sv
module intc32_ctl_regs
  import intc32_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [NSRC-1:0]             wr_data,
  output logic [NCTL-1:0][NSRC-1:0]   words
);

  for (genvar k = 0; k < NCTL; k++) begin : g_word
    localparam bit          HIGH_RST = ctl_resets_high(k);
    localparam logic [NSRC-1:0] RST_VAL = HIGH_RST ? {NSRC{1'b1}} : {NSRC{1'b0}};
    logic [NSRC-1:0] q;
    logic            hit_set;
    logic            hit_clr;

    assign hit_set = wr_en && (wr_addr == ADDR_W'(4 * k + 1));
    assign hit_clr = wr_en && (wr_addr == ADDR_W'(4 * k + 2));

    always_ff @(posedge clk) begin
      if (!rst_n)       q <= RST_VAL;
      else if (hit_set) q <= q | wr_data;
      else if (hit_clr) q <= q & ~wr_data;
    end

    assign words[k] = q;
  end

endmodule

// File: rtl/intc32_trig_eval.sv
module intc32_trig_eval
  import intc32_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] code0,
  input  logic [NSRC-1:0] code1,
  input  logic [NSRC-1:0] code2,
  input  logic [NSRC-1:0] enable,
  input  logic [NSRC-1:0] route,
  input  logic [NSRC-1:0] level,
  input  logic [NSRC-1:0] rise_ev,
  input  logic [NSRC-1:0] fall_ev,
  input  logic [NSRC-1:0] rise_clr,
  input  logic [NSRC-1:0] fall_clr,
  output logic [NSRC-1:0] rise_lat,
  output logic [NSRC-1:0] fall_lat,
  output logic [NSRC-1:0] active,
  output logic [NSRC-1:0] pend0,
  output logic [NSRC-1:0] pend1
);

  logic [NSRC-1:0] rise_en, fall_en, hi_en, lo_en;

  // per-source decode of the 3-bit trigger code
  for (genvar i = 0; i < NSRC; i++) begin : g_dec
    logic [2:0] code;
    logic [3:0] en;   // {lo, hi, fall, rise}

    assign code = {code2[i], code1[i], code0[i]};

    always_comb begin
      en = 4'b0000;
      case (code)
        TRG_RISE: en = 4'b0001;
        TRG_FALL: en = 4'b0010;
        TRG_BOTH: en = 4'b0011;
        TRG_HIGH: en = 4'b0100;
        TRG_LOW:  en = 4'b1000;
        default:  en = 4'b0000;
      endcase
    end

    assign rise_en[i] = en[0];
    assign fall_en[i] = en[1];
    assign hi_en[i]   = en[2];
    assign lo_en[i]   = en[3];
  end

  // sticky edge latches: a new event outranks a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_lat <= '0;
      fall_lat <= '0;
    end else begin
      rise_lat <= (rise_lat & ~rise_clr) | (rise_ev & rise_en);
      fall_lat <= (fall_lat & ~fall_clr) | (fall_ev & fall_en);
    end
  end

  assign active = (rise_lat & rise_en) | (fall_lat & fall_en)
                | (level & hi_en) | (~level & lo_en);

  assign pend0 = active & enable & route;
  assign pend1 = active & enable & ~route;

endmodule

// File: rtl/intc32_top.sv
module intc32_top
  import intc32_pkg::*;
#(
  parameter int NSRC        = 32,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NSRC-1:0]   reg_wdata,
  output logic [NSRC-1:0]   reg_rdata,
  output logic              irq_req0,
  output logic              irq_req1,
  output logic              wake_out
);

  logic [NCTL-1:0][NSRC-1:0] ctl;
  logic [NSRC-1:0] level, rise_ev, fall_ev;
  logic [NSRC-1:0] rise_clr, fall_clr;
  logic [NSRC-1:0] rise_lat, fall_lat, active, pend0, pend1;
  logic [NSRC-1:0] code0_w, code1_w, code2_w, ena_w, wake_w, route_w;
  logic [NSRC-1:0] test_q;
  logic            req0_q, req1_q, wake_q;

  intc32_edge_front #(.NSRC(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines   (irq_in),
    .level   (level),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  intc32_ctl_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_we),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata),
    .words   (ctl)
  );

  assign code0_w = ctl[W_CODE0];
  assign code1_w = ctl[W_CODE1];
  assign code2_w = ctl[W_CODE2];
  assign ena_w   = ctl[W_ENA];
  assign wake_w  = ctl[W_WAKE];
  assign route_w = ctl[W_ROUTE];

  assign rise_clr = (reg_we && reg_addr == ADDR_W'(A_RISE_CLR)) ? reg_wdata : '0;
  assign fall_clr = (reg_we && reg_addr == ADDR_W'(A_FALL_CLR)) ? reg_wdata : '0;

  intc32_trig_eval #(.NSRC(NSRC)) u_eval (
    .clk      (clk),
    .rst_n    (rst_n),
    .code0    (code0_w),
    .code1    (code1_w),
    .code2    (code2_w),
    .enable   (ena_w),
    .route    (route_w),
    .level    (level),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev),
    .rise_clr (rise_clr),
    .fall_clr (fall_clr),
    .rise_lat (rise_lat),
    .fall_lat (fall_lat),
    .active   (active),
    .pend0    (pend0),
    .pend1    (pend1)
  );

  // request, wake and test registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req0_q <= 1'b0;
      req1_q <= 1'b0;
      wake_q <= 1'b0;
      test_q <= '0;
    end else begin
      req0_q <= |pend0;
      req1_q <= |pend1;
      wake_q <= |(active & wake_w);
      if (reg_we && reg_addr == ADDR_W'(A_TEST)) test_q <= reg_wdata;
    end
  end

  assign irq_req0 = req0_q;
  assign irq_req1 = req1_q;
  assign wake_out = wake_q;

  // read mux
  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NCTL; k++) begin
      if (reg_addr == ADDR_W'(4 * k)) reg_rdata = ctl[k];
    end
    if (reg_addr == ADDR_W'(A_RISE_RD)) reg_rdata = rise_lat;
    if (reg_addr == ADDR_W'(A_FALL_RD)) reg_rdata = fall_lat;
    if (reg_addr == ADDR_W'(A_PEND0))   reg_rdata = pend0;
    if (reg_addr == ADDR_W'(A_PEND1))   reg_rdata = pend1;
    if (reg_addr == ADDR_W'(A_TEST))    reg_rdata = test_q;
  end

endmodule

// File: rtl/intc32_checks.sv
module intc32_checks #(
  parameter int NSRC = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] code0,
  input logic [NSRC-1:0] code1,
  input logic [NSRC-1:0] code2,
  input logic [NSRC-1:0] enable,
  input logic [NSRC-1:0] rise_lat,
  input logic [NSRC-1:0] rise_clr,
  input logic [NSRC-1:0] pend0,
  input logic [NSRC-1:0] pend1,
  input logic            req0,
  input logic            req1,
  input logic            wake
);

  // sources whose code is one of the defined trigger types
  logic [NSRC-1:0] valid_code;
  assign valid_code = (~code2 & (code0 | code1)) | (code2 & (code0 ^ code1));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!req0 && !req1 && !wake));

  p_clear_only_by_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(rise_lat) & ~rise_lat & ~$past(rise_clr)) == '0));

  p_off_codes_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (((pend0 | pend1) & ~valid_code) == '0));

  p_enable_gates_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (((pend0 | pend1) & ~enable) == '0));

  p_route_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend0 & pend1) == '0));

  p_req0_rises_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend0 != '0) |=> req0);

  p_req1_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend1 == '0) |=> !req1);

endmodule

bind intc32_top intc32_checks #(.NSRC(NSRC)) u_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .code0    (code0_w),
  .code1    (code1_w),
  .code2    (code2_w),
  .enable   (ena_w),
  .rise_lat (rise_lat),
  .rise_clr (rise_clr),
  .pend0    (pend0),
  .pend1    (pend1),
  .req0     (irq_req0),
  .req1     (irq_req1),
  .wake     (wake_out)
);

// File: tb/intc32_top_test.sv
module intc32_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_req0, irq_req1, wake_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // addresses as stated in the requirements
  localparam logic [5:0] RD_C0 = 6'd0,  SET_C0 = 6'd1,  CLR_C0 = 6'd2;
  localparam logic [5:0] RD_C1 = 6'd4,  SET_C1 = 6'd5,  CLR_C1 = 6'd6;
  localparam logic [5:0] RD_C2 = 6'd8,  SET_C2 = 6'd9,  CLR_C2 = 6'd10;
  localparam logic [5:0] RD_EN = 6'd12, SET_EN = 6'd13, CLR_EN = 6'd14;
  localparam logic [5:0] RD_WK = 6'd16, SET_WK = 6'd17, CLR_WK = 6'd18;
  localparam logic [5:0] RD_RT = 6'd20, SET_RT = 6'd21, CLR_RT = 6'd22;
  localparam logic [5:0] RD_SR = 6'd24, SET_SR = 6'd25, CLR_SR = 6'd26;
  localparam logic [5:0] RD_RISE = 6'd28, CLR_RISE = 6'd29;
  localparam logic [5:0] RD_FALL = 6'd30, CLR_FALL = 6'd31;
  localparam logic [5:0] RD_P0 = 6'd32, RD_P1 = 6'd33, A_TST = 6'd34;

  // {idx[4:0], code[2:0], enable, route, level_a, level_b, exp_p0, exp_p1}
  localparam int NVEC = 14;
  localparam logic [13:0] VEC [NVEC] = '{
    {5'd3,  3'b001, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {5'd3,  3'b001, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {5'd7,  3'b010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {5'd7,  3'b010, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {5'd12, 3'b011, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {5'd12, 3'b011, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {5'd20, 3'b101, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'd20, 3'b101, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {5'd31, 3'b110, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {5'd31, 3'b110, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {5'd0,  3'b000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {5'd5,  3'b001, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {5'd9,  3'b111, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {5'd16, 3'b100, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  intc32_top uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_req0  (irq_req0),
    .irq_req1  (irq_req1),
    .wake_out  (wake_out)
  );

  always #2 clk = ~clk;

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic quiet();
    wr(CLR_C0, '1); wr(CLR_C1, '1); wr(CLR_C2, '1);
    wr(CLR_EN, '1); wr(CLR_WK, '1);
    wr(CLR_RISE, '1); wr(CLR_FALL, '1);
  endtask

  function automatic string vec_tag(input logic [2:0] code, input logic en);
    if (!en) return "R7 disabled source";
    case (code)
      3'b001:         return "R3 rising code";
      3'b010, 3'b011: return "R4 falling/both code";
      3'b101, 3'b110: return "R5 level code";
      default:        return "R6 off code";
    endcase
  endfunction

  function automatic void summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endfunction

  initial begin
    logic [31:0] d, p0, p1, b;
    idle(5);
    // R1: safe state while reset is held
    chk("R1 req0 in reset", 32'(irq_req0), 32'h0);
    rst_n = 1'b1;
    idle(1);
    rd(RD_C0, d);   chk("R1 code plane 0", d, 32'h0);
    rd(RD_C1, d);   chk("R1 code plane 1", d, 32'h0);
    rd(RD_C2, d);   chk("R1 code plane 2", d, 32'h0);
    rd(RD_EN, d);   chk("R1 enable", d, 32'h0);
    rd(RD_WK, d);   chk("R1 wake", d, 32'h0);
    rd(RD_RT, d);   chk("R1 route", d, 32'hFFFF_FFFF);
    rd(RD_SR, d);   chk("R1 source", d, 32'hFFFF_FFFF);
    rd(RD_RISE, d); chk("R1 rise word", d, 32'h0);
    rd(RD_FALL, d); chk("R1 fall word", d, 32'h0);
    rd(A_TST, d);   chk("R1 test word", d, 32'h0);
    chk("R1 outputs", {29'b0, irq_req0, irq_req1, wake_out}, 32'h0);

    // table walk: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      logic [4:0] idx;
      logic [2:0] code;
      logic en, rt, la, lb, e0, e1;
      {idx, code, en, rt, la, lb, e0, e1} = VEC[v];
      b = 32'h1 << idx;
      quiet();
      irq_in[idx] = la;
      idle(6);
      wr(CLR_RISE, b); wr(CLR_FALL, b);
      if (code[0]) wr(SET_C0, b);
      if (code[1]) wr(SET_C1, b);
      if (code[2]) wr(SET_C2, b);
      if (en) wr(SET_EN, b);
      if (rt) wr(SET_RT, b); else wr(CLR_RT, b);
      irq_in[idx] = lb;
      idle(6);
      rd(RD_P0, p0);
      rd(RD_P1, p1);
      chk({vec_tag(code, en), " pend0 (R8)"}, 32'(p0[idx]), 32'(e0));
      chk({vec_tag(code, en), " pend1 (R8)"}, 32'(p1[idx]), 32'(e1));
      chk({vec_tag(code, en), " requests R9"}, {30'b0, irq_req0, irq_req1}, {30'b0, e0, e1});
    end

    // R2: set/clear only touch bits written as one
    quiet();
    wr(CLR_SR, 32'h0000_FFFF); rd(RD_SR, d); chk("R2 source clear", d, 32'hFFFF_0000);
    wr(SET_SR, 32'h0000_0001); rd(RD_SR, d); chk("R2 source set", d, 32'hFFFF_0001);
    wr(SET_C1, 32'h00A5_0000); rd(RD_C1, d); chk("R2 plane1 set", d, 32'h00A5_0000);
    wr(CLR_C1, 32'h0005_0000); rd(RD_C1, d); chk("R2 plane1 clear", d, 32'h00A0_0000);
    quiet();

    // R3: sticky rising latch and write-1-clear
    b = 32'h1 << 4;
    wr(SET_C0, b); wr(SET_EN, b);
    irq_in[4] = 1'b1; idle(6); irq_in[4] = 1'b0; idle(6);
    rd(RD_P0, d); chk("R3 sticky after input falls", 32'(d[4]), 32'h1);
    wr(CLR_RISE, 32'h0); rd(RD_RISE, d); chk("R3 zero write keeps latch", 32'(d[4]), 32'h1);
    wr(CLR_RISE, b); rd(RD_RISE, d); chk("R3 latch cleared", 32'(d[4]), 32'h0);
    rd(RD_P0, d); chk("R3 pending cleared", 32'(d[4]), 32'h0);

    // R7: latched edge survives a disabled source
    quiet();
    irq_in[5] = 1'b0; idle(6);
    b = 32'h1 << 5;
    wr(SET_C0, b);
    irq_in[5] = 1'b1; idle(6);
    rd(RD_P0, d);   chk("R7 disabled not pending", 32'(d[5]), 32'h0);
    chk("R7 no request", 32'(irq_req0), 32'h0);
    rd(RD_RISE, d); chk("R7 latch kept", 32'(d[5]), 32'h1);
    wr(SET_EN, b); idle(2);
    rd(RD_P0, d);   chk("R7 pending after enable", 32'(d[5]), 32'h1);
    chk("R7 request after enable", 32'(irq_req0), 32'h1);

    // R9: exact latency of a level source on output 1
    quiet();
    b = 32'h1 << 2;
    wr(SET_C0, b); wr(SET_C2, b); wr(SET_EN, b); wr(CLR_RT, b);
    idle(2);
    irq_in[2] = 1'b1;
    idle(1);
    rd(RD_P1, d); chk("R9 pend1 after one clock", 32'(d[2]), 32'h0);
    idle(1);
    rd(RD_P1, d); chk("R9 pend1 after two clocks", 32'(d[2]), 32'h1);
    chk("R9 req1 not yet", 32'(irq_req1), 32'h0);
    idle(1);
    chk("R9 req1 after three clocks", 32'(irq_req1), 32'h1);
    irq_in[2] = 1'b0; idle(4);
    chk("R5 level released", 32'(irq_req1), 32'h0);

    // R10: wake ignores the enable word
    quiet();
    b = 32'h1 << 8;
    wr(SET_C0, b); wr(SET_C2, b); wr(SET_WK, b);
    irq_in[8] = 1'b1; idle(4);
    chk("R10 wake high", 32'(wake_out), 32'h1);
    chk("R10 no request while disabled", {30'b0, irq_req0, irq_req1}, 32'h0);
    irq_in[8] = 1'b0; idle(4);
    chk("R10 wake low when inactive", 32'(wake_out), 32'h0);

    // R11: edge and clear on the same clock edge
    quiet();
    b = 32'h1 << 10;
    wr(SET_C0, b); wr(SET_EN, b);
    idle(2);
    irq_in[10] = 1'b1;   // reaches the latch on the third rising edge
    idle(2);
    wr(CLR_RISE, b);     // captured on that same third rising edge
    rd(RD_RISE, d); chk("R11 edge wins over clear", 32'(d[10]), 32'h1);
    wr(CLR_RISE, b);
    rd(RD_RISE, d); chk("R11 later clear works", 32'(d[10]), 32'h0);

    // R12: test word
    quiet();
    wr(A_TST, 32'h1234_5678);
    rd(A_TST, d); chk("R12 test word", d, 32'h1234_5678);
    rd(RD_P0, d); chk("R12 pend0 untouched", d, 32'h0);
    rd(RD_P1, d); chk("R12 pend1 untouched", d, 32'h0);

    // R1: reset again after writes
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
    rd(RD_RT, d); chk("R1 route after re-reset", d, 32'hFFFF_FFFF);
    rd(RD_SR, d); chk("R1 source after re-reset", d, 32'hFFFF_FFFF);
    rd(A_TST, d); chk("R1 test after re-reset", d, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule